// File: doc/BRIEF.md
# Iterative AES Round Engine

This block runs the AES cipher on one 128-bit block at a time with a single round engine that is used again for every round. A state register sits inside the round, right after the byte-substitution layer. In each clock, the linear back half of round i (row shift, column mixing, key addition) and the substitution front half of round i+1 are evaluated together. As a result, one full round completes per clock and nothing of the round is unrolled. Encryption and decryption share the same substitution hardware and the same state register. A mode input picks the direction when a block is launched.

Round keys come from an external key scheduler. The engine publishes the index of the round key it needs in the current cycle, and the scheduler answers on the round-key input in the same cycle. The engine supports 128-, 192- and 256-bit master keys, which give 10, 12 or 14 rounds.

Top module: `aes_iter_core`

## Requirements
- R1: While reset is high and in the first cycle after it, `dout` is all zero and `done` is low. With `decrypt` low and no block running, `rk_idx` is 0.
- R2: With `decrypt` = 0, the result is the AES encryption of `din` under the round keys supplied. The three standard 128/192/256-bit test cases (plaintext 00112233…eeff, key bytes 00,01,02,… ascending) must be reproduced.
- R3: With `decrypt` = 1, the result is the AES decryption of `din`. Each standard ciphertext must return the standard plaintext.
- R4: `key_len` selects the round count: 0 gives 10 rounds, 1 gives 12 rounds, 2 gives 14 rounds, and 3 is treated the same as 2.
- R5: `rk_idx` starts in the cycle `start` is accepted and moves by one key per cycle. For encryption it counts 0,1,…,Nr. For decryption it counts Nr,Nr−1,…,0.
- R6: `done` is high for exactly one cycle. That cycle directly follows the (Nr+1)-th rising edge, counted from and including the edge that samples `start`.
- R7: While a block is running, `start`, `decrypt`, `key_len` and `din` are ignored. The key sequence and the result of the running block are unchanged.
- R8: `dout` changes only when `done` rises, and it holds its value until the next completion.
- R9: A new `start` is accepted in the same cycle that `done` is high, so blocks can run with no gap between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a block (taken only when idle) |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt; sampled with start |
| key_len | input | 2 | 0: 128-bit, 1: 192-bit, 2 or 3: 256-bit key |
| din | input | 128 | Input block, byte 0 in bits 127:120 |
| rkey | input | 128 | Round key selected by rk_idx, same cycle |
| rk_idx | output | 4 | Index of round key needed this cycle |
| dout | output | 128 | Registered result block |
| done | output | 1 | One-cycle pulse when dout is updated |

## Verification
Each standard vector is run in both directions for all three key lengths. A fault in the forward or the inverse transforms therefore shows up on its own, and a wrong round count shows up only on the key length it affects. Key code 3 is run against the 256-bit answer, which separates it from the 128-bit decode. One run flips `start`, `decrypt`, `key_len` and `din` in the middle of the block. Another run launches the next block in the cycle `done` is high, which separates correct acceptance timing from an engine that needs an idle cycle. In every run the bench also logs the key index sequence, the cycle of the done pulse and the hold of `dout` between completions.

// File: rtl/aes_core_pkg.sv
package aes_core_pkg;
  localparam int BLK_W   = 128;
  localparam int NBYTES  = BLK_W / 8;
  localparam int IDX_W   = 4;
  localparam int KSEL_W  = 2;
  localparam int NR_BASE = 10;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, t;
    r = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ t;
      t = xt(t);
    end
    return r;
  endfunction

  // multiplicative inverse as x^254; zero maps to zero
  function automatic logic [7:0] ginv(input logic [7:0] x);
    logic [7:0] r, s;
    r = 8'h01;
    s = x;
    for (int i = 0; i < 7; i++) begin
      s = gmul(s, s);
      r = gmul(r, s);
    end
    return r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] aff(input logic [7:0] b);
    return b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_aff(input logic [7:0] b);
    return rl(b, 1) ^ rl(b, 3) ^ rl(b, 6) ^ 8'h05;
  endfunction

  function automatic logic [BLK_W-1:0] shift_rows(input logic [BLK_W-1:0] s,
                                                  input logic inv);
    logic [BLK_W-1:0] o;
    int src;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        src = inv ? (c - r + 4) % 4 : (c + r) % 4;
        o[BLK_W-1-8*(r+4*c) -: 8] = s[BLK_W-1-8*(r+4*src) -: 8];
      end
    return o;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] c, input logic inv);
    logic [7:0] a [4];
    logic [7:0] k0, k1, k2, k3;
    logic [31:0] o;
    for (int i = 0; i < 4; i++) a[i] = c[31-8*i -: 8];
    k0 = inv ? 8'h0e : 8'h02;
    k1 = inv ? 8'h0b : 8'h03;
    k2 = inv ? 8'h0d : 8'h01;
    k3 = inv ? 8'h09 : 8'h01;
    for (int i = 0; i < 4; i++)
      o[31-8*i -: 8] = gmul(a[i], k0) ^ gmul(a[(i+1)%4], k1) ^
                       gmul(a[(i+2)%4], k2) ^ gmul(a[(i+3)%4], k3);
    return o;
  endfunction

  function automatic logic [BLK_W-1:0] mix_all(input logic [BLK_W-1:0] s,
                                               input logic inv);
    logic [BLK_W-1:0] o;
    for (int c = 0; c < 4; c++)
      o[BLK_W-1-32*c -: 32] = mix_col(s[BLK_W-1-32*c -: 32], inv);
    return o;
  endfunction
endpackage

// File: rtl/aes_sbox_dual.sv
module aes_sbox_dual
  import aes_core_pkg::*;
(
  input  logic       inv,
  input  logic [7:0] x,
  output logic [7:0] y
);
  logic [7:0] pre, g;

  // one field inverter serves both directions
  always_comb begin
    pre = inv ? inv_aff(x) : x;
    g   = ginv(pre);
    y   = inv ? g : aff(g);
  end
endmodule

// File: rtl/aes_round_half.sv
module aes_round_half
  import aes_core_pkg::*;
(
  input  logic             inv,
  input  logic             first,
  input  logic [BLK_W-1:0] st,
  input  logic [BLK_W-1:0] blk_in,
  input  logic [BLK_W-1:0] rk,
  output logic [BLK_W-1:0] nxt,
  output logic [BLK_W-1:0] fin
);
  logic [BLK_W-1:0] y, sb;

  // back half of round i feeding the front half of round i+1
  always_comb begin
    if (first)    y = blk_in ^ rk;
    else if (inv) y = mix_all(st ^ rk, 1'b1);
    else          y = mix_all(shift_rows(st, 1'b0), 1'b0) ^ rk;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_sb
    aes_sbox_dual u_sb (
      .inv (inv),
      .x   (y[BLK_W-1-8*b -: 8]),
      .y   (sb[BLK_W-1-8*b -: 8])
    );
  end

  always_comb begin
    nxt = inv ? shift_rows(sb, 1'b1) : sb;
    fin = inv ? (st ^ rk) : (shift_rows(st, 1'b0) ^ rk);
  end
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              decrypt,
  input  logic [KSEL_W-1:0] key_len,
  input  logic [BLK_W-1:0]  din,
  input  logic [BLK_W-1:0]  rkey,
  output logic [IDX_W-1:0]  rk_idx,
  output logic [BLK_W-1:0]  dout,
  output logic              done
);
  logic             busy, dec_q, first, inv;
  logic [IDX_W-1:0] cnt, nr_q, nr_in;
  logic [BLK_W-1:0] st, nxt, fin;

  always_comb begin
    case (key_len)
      2'd0:    nr_in = IDX_W'(NR_BASE);
      2'd1:    nr_in = IDX_W'(NR_BASE + 2);
      default: nr_in = IDX_W'(NR_BASE + 4);
    endcase
    first = start & ~busy;
    inv   = busy ? dec_q : decrypt;
    if (!busy) rk_idx = decrypt ? nr_in : '0;
    else       rk_idx = dec_q ? (nr_q - cnt) : cnt;
  end

  aes_round_half u_rh (
    .inv    (inv),
    .first  (first),
    .st     (st),
    .blk_in (din),
    .rk     (rkey),
    .nxt    (nxt),
    .fin    (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      dec_q <= 1'b0;
      cnt   <= '0;
      nr_q  <= '0;
      st    <= '0;
      dout  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (first) begin
        st    <= nxt;
        busy  <= 1'b1;
        cnt   <= IDX_W'(1);
        dec_q <= decrypt;
        nr_q  <= nr_in;
      end else if (busy) begin
        if (cnt == nr_q) begin
          dout <= fin;
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          st  <= nxt;
          cnt <= cnt + IDX_W'(1);
        end
      end
    end
  end

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_dout_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dout));
  a_r5_enc_idx_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !dec_q) |-> (rk_idx == $past(rk_idx) + IDX_W'(1)));
  a_r5_dec_idx_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && dec_q) |-> (rk_idx == $past(rk_idx) - IDX_W'(1)));
endmodule

// File: tb/sim_aes_iter_core.sv
module sim_aes_iter_core;
  logic         clk = 1'b0;
  logic         rst, start, decrypt;
  logic [1:0]   key_len;
  logic [127:0] din, rkey, dout;
  logic [3:0]   rk_idx;
  logic         done;

  int checks = 0, fails = 0, cycles = 0, cur = 0;
  logic [7:0]   sb [256];
  logic [127:0] rks [0:2][0:14];
  logic [127:0] last_out;

  localparam logic [127:0] PT  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C0  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] C1  = 128'hdda97ca4864cdfe06eaf70a0ec0d7191;
  localparam logic [127:0] C2  = 128'h8ea2b7ca516745bfeafc49904b496089;
  localparam int           VKL  [0:5] = '{0, 1, 2, 0, 1, 2};
  localparam bit           VDEC [0:5] = '{0, 0, 0, 1, 1, 1};
  localparam logic [127:0] VIN  [0:5] = '{PT, PT, PT, C0, C1, C2};
  localparam logic [127:0] VEXP [0:5] = '{C0, C1, C2, PT, PT, PT};

  always #2.5 clk = ~clk;

  aes_iter_core u0 (.clk(clk), .rst(rst), .start(start), .decrypt(decrypt),
    .key_len(key_len), .din(din), .rkey(rkey), .rk_idx(rk_idx),
    .dout(dout), .done(done));

  assign rkey = rks[cur][rk_idx];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] rot8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] got,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic build_tables();
    logic [7:0] p, q;
    logic [31:0] w [0:59];
    logic [31:0] t;
    logic [7:0] rc;
    int nk;
    p = 8'h01; q = 8'h01;
    for (int i = 0; i < 255; i++) begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rot8(q, 1) ^ rot8(q, 2) ^ rot8(q, 3) ^ rot8(q, 4) ^ 8'h63;
    end
    sb[0] = 8'h63;
    for (int kl = 0; kl < 3; kl++) begin
      nk = 4 + 2 * kl;
      rc = 8'h01;
      for (int i = 0; i < 60; i++) begin
        if (i < nk) w[i] = {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)};
        else begin
          t = w[i-1];
          if (i % nk == 0) begin
            t = {t[23:0], t[31:24]};
            t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
            rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
          end else if (nk > 6 && i % nk == 4)
            t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
          w[i] = w[i-nk] ^ t;
        end
      end
      for (int r = 0; r < 15; r++) rks[kl][r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    end
  endtask

  // starts at a falling edge, returns at the falling edge where done is high
  task automatic run(input int kl, input bit dec, input logic [127:0] d,
                     input logic [127:0] e, input string tag, input bit poke);
    int nr;
    bit idx_ok, quiet_ok, hold_ok;
    logic [3:0] ex;
    cur = (kl >= 2) ? 2 : kl;
    nr = 10 + 2 * cur;
    key_len = 2'(kl); decrypt = dec; din = d; start = 1'b1;
    idx_ok = 1; quiet_ok = 1; hold_ok = 1;
    #1;
    ex = dec ? 4'(nr) : 4'd0;
    if (rk_idx !== ex) idx_ok = 0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= nr; k++) begin
      if (poke && k == 3) begin
        start = 1'b1; decrypt = ~dec; key_len = 2'd1; din = ~d;
      end
      if (poke && k == 5) start = 1'b0;
      #1;
      ex = dec ? 4'(nr - k) : 4'(k);
      if (rk_idx !== ex) idx_ok = 0;
      if (done !== 1'b0) quiet_ok = 0;
      if (dout !== last_out) hold_ok = 0;
      @(negedge clk);
    end
    chk(idx_ok, {"R5 key order ", tag}, 128'(rk_idx), 128'(ex));
    chk(quiet_ok, {"R6 no early done ", tag}, 128'(done), 128'd0);
    chk(hold_ok, {"R8 dout hold ", tag}, dout, last_out);
    chk(done === 1'b1, {"R6 done timing ", tag}, 128'(done), 128'd1);
    chk(dout === e, {tag, " result"}, dout, e);
    last_out = e;
  endtask

  initial begin
    build_tables();
    rst = 1'b1; start = 1'b0; decrypt = 1'b0; key_len = 2'd0; din = '0;
    last_out = '0;
    repeat (3) @(negedge clk);
    chk(dout === '0 && done === 1'b0, "R1 reset held", dout, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(dout === '0 && done === 1'b0 && rk_idx === 4'd0, "R1 after reset",
        {dout[123:0], rk_idx}, '0);

    for (int v = 0; v < 6; v++) begin
      run(VKL[v], VDEC[v], VIN[v], VEXP[v],
          VDEC[v] ? $sformatf("R3 R4 dec kl%0d", VKL[v]) : $sformatf("R2 R4 enc kl%0d", VKL[v]),
          1'b0);
      @(negedge clk);
      chk(done === 1'b0, "R6 done single cycle", 128'(done), 128'd0);
    end

    run(3, 1'b0, PT, C2, "R4 code3 as 256", 1'b0);
    @(negedge clk);

    run(0, 1'b0, PT, C0, "R7 inputs ignored while busy", 1'b1);
    run(2, 1'b1, C2, PT, "R9 back-to-back start", 1'b0);
    @(negedge clk);
    chk(done === 1'b0 && dout === PT, "R8 hold after R9", dout, PT);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule